// File: doc/BRIEF.md
# Scatter-Gather Page-Table Walker

This block turns a bus address that has already been matched to an enabled scatter-gather window into a DMA address. It works from three values: the bus address, the window's size-mask register and the window's translated-base register. From these it forms the byte address of one 64-bit page-table entry and issues a single read for it on a valid/ready memory request port. When the read data arrives, the block keeps the entry's frame bits and drops the entry's lowest bit. It then places those frame bits above a 13-bit (8 KB) page offset taken from the bus address. The result is cut to a 34-bit DMA address and handed out on a valid/ready response port.

The walker handles one lookup at a time. It accepts a request only when it is idle. The address is reduced to the entry address plus the page offset on the accepting edge, so the caller may change its address and window registers at once. Window matching, entry caching and memory error handling belong to neighbouring logic.

Top module: `sgx_table_walker`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1 and both `mem_valid` and `rsp_valid` are 0.
- R2: A lookup is taken on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 and further `req_valid` is ignored. This lasts until the result has been taken on a rising edge where `rsp_valid` and `rsp_ready` are both 1; in the cycle after that, `req_ready` is 1 again.
- R3: Let W be the size mask restricted to bits 31..20. `mem_addr` is formed from two parts OR-ed together. The first part is the translated base with bits 9..0 cleared and with every bit (W >> 10) set also cleared. The second part is the bus address, masked to bits 19..13 together with the bits set in W, then shifted right by 10. Consequently bits 2..0 of `mem_addr` are always 0.
- R4: `mem_valid` rises in the cycle after acceptance. It holds with an unchanged `mem_addr` until a rising edge with `mem_ready` = 1, then falls. Exactly one memory request is issued per lookup.
- R5: Read data is taken only on a rising edge with `rd_valid` = 1 after the memory request has been accepted. `rd_valid` pulses while idle or while the request is still pending have no effect.
- R6: The DMA address equals the 64-bit entry with bit 0 cleared and shifted left by 12, OR-ed with bits 12..0 of the bus address. `rsp_valid` rises in the cycle after read data is taken.
- R7: The DMA address is truncated to 34 bits. Entry bits above bit 21 never reach `rsp_dma_addr`.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_dma_addr` is unchanged.
- R9: Changing `req_bus_addr`, `req_win_mask` or `req_tbase` after the accepting edge changes neither `mem_addr` nor `rsp_dma_addr` of the lookup in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to take a lookup |
| req_bus_addr | input | 64 | Bus address to translate |
| req_win_mask | input | 64 | Size-mask register of the matched window |
| req_tbase | input | 64 | Translated-base register of the matched window |
| mem_valid | output | 1 | Entry read request present |
| mem_ready | input | 1 | Memory accepts the entry read |
| mem_addr | output | 64 | Byte address of the page-table entry |
| rd_valid | input | 1 | Entry read data present |
| rd_data | input | 64 | Page-table entry returned by memory |
| rsp_valid | output | 1 | Translated address present |
| rsp_ready | input | 1 | Consumer takes the translated address |
| rsp_dma_addr | output | 34 | Translated DMA address |

## Verification
A corrupt held entry address or page offset does not stay hidden. The entry address shows on `mem_addr` in the cycle after acceptance, and the offset shows in the low 13 bits of `rsp_dma_addr` one cycle after read data is taken. A control state that is out of step shows up as valid or ready flags at the wrong time. It could, for example, show `req_ready` high alongside `mem_valid`, a second memory request, or a response with no preceding read data. Such an error appears within a cycle of the faulty transition. The bench changes the request inputs right after acceptance and pulses `rd_valid` at the wrong times, so a design that fails to isolate its held state gives wrong values on the same lookup.

// File: rtl/sgx_walk_pkg.sv
package sgx_walk_pkg;

   // Lookup control states, in the order a lookup passes through them.
   typedef enum logic [1:0] {
      WS_IDLE    = 2'd0,
      WS_FETCH   = 2'd1,
      WS_AWAIT   = 2'd2,
      WS_DELIVER = 2'd3
   } walk_state_e;

endpackage

// File: rtl/sgx_entry_locator.sv
// Forms the page-table entry byte address from the bus address and the
// window's size mask and translated base.
module sgx_entry_locator #(
   parameter int BUS_AW    = 64,
   parameter int OFS_W     = 13,
   parameter int WIN_LO    = 20,
   parameter int WIN_HI    = 31,
   parameter int XLT_SHIFT = 10
) (
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_AW-1:0] win_mask,
   input  logic [BUS_AW-1:0] tbase,
   output logic [BUS_AW-1:0] entry_addr
);

   localparam logic [BUS_AW-1:0] ONE     = {{(BUS_AW-1){1'b0}}, 1'b1};
   localparam logic [BUS_AW-1:0] WIN_SEL = (ONE << (WIN_HI + 1)) - (ONE << WIN_LO);
   localparam logic [BUS_AW-1:0] IDX_SEL = (ONE << WIN_LO) - (ONE << OFS_W);
   localparam logic [BUS_AW-1:0] LOW_CLR = (ONE << XLT_SHIFT) - ONE;

   if (WIN_HI >= BUS_AW) begin : g_bad_win_hi
      $error("window field exceeds bus address width");
   end
   if (WIN_LO <= OFS_W) begin : g_bad_win_lo
      $error("window field must sit above the entry index");
   end
   if (XLT_SHIFT >= OFS_W) begin : g_bad_shift
      $error("entry shift must be smaller than the page offset width");
   end

   logic [BUS_AW-1:0] win_bits;
   logic [BUS_AW-1:0] base_keep;
   logic [BUS_AW-1:0] addr_sel;

   always_comb begin
      win_bits   = win_mask & WIN_SEL;
      base_keep  = ~((win_bits >> XLT_SHIFT) | LOW_CLR);
      addr_sel   = win_bits | IDX_SEL;
      entry_addr = (tbase & base_keep) | ((bus_addr & addr_sel) >> XLT_SHIFT);
   end

endmodule

// File: rtl/sgx_addr_composer.sv
// Joins the frame bits of a returned entry with the page offset.
module sgx_addr_composer #(
   parameter int BUS_AW = 64,
   parameter int DMA_AW = 34,
   parameter int OFS_W  = 13
) (
   input  logic [BUS_AW-1:0] entry,
   input  logic [OFS_W-1:0]  page_ofs,
   output logic [DMA_AW-1:0] dma_addr
);

   localparam int PFN_SHIFT = OFS_W - 1;
   localparam logic [BUS_AW-1:0] DROP_LSB = ~{{(BUS_AW-1){1'b0}}, 1'b1};

   if (DMA_AW <= OFS_W) begin : g_bad_dma
      $error("DMA address must be wider than the page offset");
   end

   logic [BUS_AW-1:0] full_addr;

   always_comb begin
      full_addr = ((entry & DROP_LSB) << PFN_SHIFT)
                | {{(BUS_AW-OFS_W){1'b0}}, page_ofs};
   end

   if (DMA_AW <= BUS_AW) begin : g_trunc
      assign dma_addr = full_addr[DMA_AW-1:0];
   end else begin : g_extend
      assign dma_addr = {{(DMA_AW-BUS_AW){1'b0}}, full_addr};
   end

endmodule

// File: rtl/sgx_walk_ctrl.sv
// One-lookup-at-a-time control machine with valid/ready on both sides.
module sgx_walk_ctrl
   import sgx_walk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_ready,
   input  logic rd_valid,
   input  logic rsp_ready,
   output logic req_ready,
   output logic mem_valid,
   output logic rsp_valid,
   output logic take_req,
   output logic take_data
);

   walk_state_e st_q, st_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WS_IDLE;
      else        st_q <= st_nx;
   end

   always_comb begin
      st_nx = st_q;
      case (st_q)
         WS_IDLE:    if (req_valid) st_nx = WS_FETCH;
         WS_FETCH:   if (mem_ready) st_nx = WS_AWAIT;
         WS_AWAIT:   if (rd_valid)  st_nx = WS_DELIVER;
         WS_DELIVER: if (rsp_ready) st_nx = WS_IDLE;
         default:    st_nx = WS_IDLE;
      endcase
   end

   assign req_ready = (st_q == WS_IDLE);
   assign mem_valid = (st_q == WS_FETCH);
   assign rsp_valid = (st_q == WS_DELIVER);
   assign take_req  = req_ready && req_valid;
   assign take_data = (st_q == WS_AWAIT) && rd_valid;

   assert_idle_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_valid && !rsp_valid));

   assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |=> !req_ready);

   assert_ready_after_handoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> req_ready);

   assert_request_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> mem_valid);

   assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> !mem_valid);

   assert_data_before_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(rd_valid));

   assert_response_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid);

endmodule

// File: rtl/sgx_table_walker.sv
// Scatter-gather page-table walker: entry address, single read, DMA address.
module sgx_table_walker #(
   parameter int BUS_AW    = 64,
   parameter int DMA_AW    = 34,
   parameter int OFS_W     = 13,
   parameter int WIN_LO    = 20,
   parameter int WIN_HI    = 31,
   parameter int XLT_SHIFT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_AW-1:0] req_bus_addr,
   input  logic [BUS_AW-1:0] req_win_mask,
   input  logic [BUS_AW-1:0] req_tbase,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [BUS_AW-1:0] mem_addr,
   input  logic              rd_valid,
   input  logic [BUS_AW-1:0] rd_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DMA_AW-1:0] rsp_dma_addr
);

   localparam int ALIGN_W = OFS_W - XLT_SHIFT;

   logic              take_req;
   logic              take_data;
   logic [BUS_AW-1:0] entry_addr_d;
   logic [BUS_AW-1:0] entry_addr_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DMA_AW-1:0] dma_d;
   logic [DMA_AW-1:0] dma_q;

   sgx_walk_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mem_ready (mem_ready),
      .rd_valid  (rd_valid),
      .rsp_ready (rsp_ready),
      .req_ready (req_ready),
      .mem_valid (mem_valid),
      .rsp_valid (rsp_valid),
      .take_req  (take_req),
      .take_data (take_data)
   );

   sgx_entry_locator #(
      .BUS_AW    (BUS_AW),
      .OFS_W     (OFS_W),
      .WIN_LO    (WIN_LO),
      .WIN_HI    (WIN_HI),
      .XLT_SHIFT (XLT_SHIFT)
   ) u_locate (
      .bus_addr   (req_bus_addr),
      .win_mask   (req_win_mask),
      .tbase      (req_tbase),
      .entry_addr (entry_addr_d)
   );

   sgx_addr_composer #(
      .BUS_AW (BUS_AW),
      .DMA_AW (DMA_AW),
      .OFS_W  (OFS_W)
   ) u_compose (
      .entry    (rd_data),
      .page_ofs (ofs_q),
      .dma_addr (dma_d)
   );

   // Lookup reduced to entry address plus page offset on the accepting edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_addr_q <= '0;
         ofs_q        <= '0;
      end else if (take_req) begin
         entry_addr_q <= entry_addr_d;
         ofs_q        <= req_bus_addr[OFS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dma_q <= '0;
      else if (take_data) dma_q <= dma_d;
   end

   assign mem_addr     = entry_addr_q;
   assign rsp_dma_addr = dma_q;

   assert_entry_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[ALIGN_W-1:0] == '0));

   assert_request_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> $stable(mem_addr));

   assert_response_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> $stable(rsp_dma_addr));

   assert_held_addr_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !take_req) |=> $stable(mem_addr));

endmodule

// File: tb/test_sgx_table_walker.sv
module test_sgx_table_walker;

   typedef struct packed {
      logic [63:0] addr;
      logic [63:0] mask;
      logic [63:0] tbase;
      logic [63:0] entry;
      logic [63:0] exp_pte;
      logic [33:0] exp_dma;
      logic [3:0]  mem_stall;
      logic [3:0]  data_gap;
      logic [3:0]  rsp_stall;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{64'h0000_0000_0012_3456, 64'h0, 64'h0000_0000_0040_0000,
        64'h0000_0000_0001_2345, 64'h0000_0000_0040_0088, 34'h0_1234_5456,
        4'd0, 4'd0, 4'd0},
      '{64'h0000_0000_8035_E7FF, 64'h0000_0000_0030_0000, 64'h0000_0000_1234_5678,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_1234_5D78, 34'h3_FFFF_E7FF,
        4'd2, 4'd1, 4'd3},
      '{64'hDEAD_BEEF_CAFE_1234, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00AB_CDEF_0123,
        64'h0000_0000_0000_0002, 64'h0000_00AB_CDF2_BF80, 34'h0_0000_3234,
        4'd1, 4'd3, 4'd1},
      '{64'h0000_0000_0000_1FFF, 64'h0, 64'h0,
        64'h0000_0000_0000_0001, 64'h0, 34'h0_0000_1FFF,
        4'd0, 4'd2, 4'd0},
      '{64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_000F_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0020_0001, 64'hFFFF_FFFF_FFFF_FFF8, 34'h2_0000_1FFF,
        4'd3, 4'd0, 4'd2},
      '{64'h0000_0000_0000_2000, 64'h0, 64'h0000_0000_0000_1000,
        64'h0000_0000_0040_0000, 64'h0000_0000_0000_1008, 34'h0,
        4'd1, 4'd1, 4'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_bus_addr = '0;
   logic [63:0] req_win_mask = '0;
   logic [63:0] req_tbase = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [63:0] mem_addr;
   logic        rd_valid = 1'b0;
   logic [63:0] rd_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [33:0] rsp_dma_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sgx_table_walker i_sgx_table_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_bus_addr (req_bus_addr),
      .req_win_mask (req_win_mask),
      .req_tbase    (req_tbase),
      .mem_valid    (mem_valid),
      .mem_ready    (mem_ready),
      .mem_addr     (mem_addr),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .rsp_valid    (rsp_valid),
      .rsp_ready    (rsp_ready),
      .rsp_dma_addr (rsp_dma_addr)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      chk(req_ready === 1'b1 && mem_valid === 1'b0 && rsp_valid === 1'b0, tag,
          {61'd0, req_ready, mem_valid, rsp_valid}, 64'h4);
   endtask

   // One full lookup; noise pulses rd_valid and req_valid at moments they must be ignored.
   task automatic run_lookup(input vec_t v, input bit noise);
      @(negedge clk);
      req_bus_addr = v.addr;
      req_win_mask = v.mask;
      req_tbase    = v.tbase;
      req_valid    = 1'b1;
      @(negedge clk);
      req_valid    = noise;
      req_bus_addr = ~v.addr;
      req_win_mask = ~v.mask;
      req_tbase    = ~v.tbase;
      chk(req_ready === 1'b0, "R2 busy after accept", {63'd0, req_ready}, 64'd0);
      chk(mem_valid === 1'b1 && mem_addr === v.exp_pte, "R3 R9 entry address",
          mem_addr, v.exp_pte);
      for (int k = 0; k < int'(v.mem_stall); k++) begin
         rd_valid = noise;
         rd_data  = 64'hFFFF_0000_FFFF_0000;
         @(negedge clk);
         chk(mem_valid === 1'b1 && mem_addr === v.exp_pte, "R4 R5 request held",
             mem_addr, v.exp_pte);
      end
      rd_valid  = 1'b0;
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk(mem_valid === 1'b0, "R4 single request", {63'd0, mem_valid}, 64'd0);
      for (int k = 0; k < int'(v.data_gap); k++) begin
         @(negedge clk);
         chk(rsp_valid === 1'b0 && mem_valid === 1'b0, "R5 waits for data",
             {62'd0, rsp_valid, mem_valid}, 64'd0);
      end
      rd_valid = 1'b1;
      rd_data  = v.entry;
      @(negedge clk);
      rd_valid  = 1'b0;
      rd_data   = 64'h1234_5678_9ABC_DEF1;
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1 && rsp_dma_addr === v.exp_dma, "R6 R7 R9 DMA address",
          {30'd0, rsp_dma_addr}, {30'd0, v.exp_dma});
      for (int k = 0; k < int'(v.rsp_stall); k++) begin
         @(negedge clk);
         chk(rsp_valid === 1'b1 && rsp_dma_addr === v.exp_dma, "R8 response held",
             {30'd0, rsp_dma_addr}, {30'd0, v.exp_dma});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check_idle("R2 idle after handoff");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R2 lookup did not finish actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2;
      check_idle("R1 during reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // Table of lookups.
      for (int i = 0; i < NVEC; i++) run_lookup(VECS[i], (i % 2) == 1);

      // R5: read data while idle is ignored.
      rd_valid = 1'b1;
      rd_data  = 64'h0000_0000_0000_4000;
      @(negedge clk);
      rd_valid = 1'b0;
      check_idle("R5 stray data in idle");
      chk(rsp_dma_addr === VECS[NVEC-1].exp_dma, "R5 result untouched by stray data",
          {30'd0, rsp_dma_addr}, {30'd0, VECS[NVEC-1].exp_dma});

      // Back-to-back: a lookup right after the previous handoff.
      run_lookup(VECS[1], 1'b1);

      // R1: reset in the middle of a lookup returns to the idle state.
      @(negedge clk);
      req_bus_addr = VECS[0].addr;
      req_win_mask = VECS[0].mask;
      req_tbase    = VECS[0].tbase;
      req_valid    = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_valid === 1'b1, "R4 request raised before reset", {63'd0, mem_valid}, 64'd1);
      rst_n = 1'b0;
      #1;
      check_idle("R1 reset mid lookup");
      chk(rsp_dma_addr === 34'd0 && mem_addr === 64'd0, "R1 cleared outputs",
          mem_addr, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 idle after reset release");

      run_lookup(VECS[2], 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule